// File: doc/BRIEF.md
# System Bus Address Decoder

This block decodes a 24-bit system address, given as an 8-bit bank and a 16-bit offset, against one fixed banked memory map. It raises a select for the CPU-side memory-mapped register space. It also raises a select for work RAM and forms the 17-bit work-RAM byte address that goes with it. When neither region claims the address, it raises an unmapped flag instead. The block is purely combinational. The bus master places the address on the inputs, and the outputs settle in the same cycle. Downstream register files and the RAM macro use the outputs to steer the access.

There are four register windows. They are visible only in the two I/O bank ranges, 0x00–0x3F and 0x80–0xBF. The same two bank ranges also expose the first 8 KiB of work RAM at the bottom of every bank. Banks 0x7E and 0x7F together open the whole 128 KiB of work RAM, one 64 KiB half in each bank.

Top module: `sys_addr_decoder`

## Requirements
- R1: In an I/O bank, offsets 0x2140 to 0x2183 inclusive assert `mmio_sel`.
- R2: In an I/O bank, offsets 0x4016 and 0x4017 assert `mmio_sel`.
- R3: In an I/O bank, offsets 0x4200 to 0x421F inclusive assert `mmio_sel`.
- R4: In an I/O bank, offsets 0x4300 to 0x437F inclusive assert `mmio_sel`.
- R5: I/O banks are 0x00–0x3F and 0x80–0xBF (bank bit 6 clear). In any other bank, `mmio_sel` stays low for every offset.
- R6: In an I/O bank, offsets 0x0000 to 0x1FFF assert `wram_sel`. In that case `wram_addr` equals offset bits 12:0 with bits 16:13 zero.
- R7: In banks 0x7E and 0x7F, every offset asserts `wram_sel`. In that case `wram_addr` equals bank bit 0 in bit 16, followed by the 16-bit offset.
- R8: At most one of `mmio_sel` and `wram_sel` is high. `unmapped` is high exactly when both are low.
- R9: While `wram_sel` is low, `wram_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bank | input | 8 | Address bits 23:16 |
| offset | input | 16 | Address bits 15:0 |
| mmio_sel | output | 1 | Register-window select |
| wram_sel | output | 1 | Work-RAM select |
| wram_addr | output | 17 | Work-RAM byte address |
| unmapped | output | 1 | No region claims the address |

## Verification
The block holds no state, so a decode error shows at the ports in the same cycle as the address that triggers it. Errors of this kind sit at the edges of regions: a window bound that is off by one, a bank-range test that takes the wrong bit, or a mirror that keeps too many offset bits. The stimulus therefore crosses both ends of each window and each bank boundary. At each of those points it compares all four outputs against a model of the map kept inside the bench.

// File: rtl/sysbus_map_pkg.sv
// Package: geometry of the fixed system memory map.
// Assumes the 8-bit bank / 16-bit offset split and four register windows.
package sysbus_map_pkg;
    localparam int BANK_W   = 8;
    localparam int OFS_W    = 16;
    localparam int WRAM_AW  = 17;
    localparam int LOW_AW   = 13;
    localparam int NUM_WIN  = 4;

    typedef struct packed {
        logic [OFS_W-1:0] lo;
        logic [OFS_W-1:0] hi;
    } win_t;

    // Inclusive bounds of register window idx.
    function automatic win_t win_of(input int idx);
        win_t w;
        case (idx)
            0:       begin w.lo = 16'h2140; w.hi = 16'h2183; end
            1:       begin w.lo = 16'h4016; w.hi = 16'h4017; end
            2:       begin w.lo = 16'h4200; w.hi = 16'h421F; end
            default: begin w.lo = 16'h4300; w.hi = 16'h437F; end
        endcase
        return w;
    endfunction
endpackage

// File: rtl/bank_class_dec.sv
// Classifies a bank number. io_bank marks banks 0x00-0x3F and 0x80-0xBF.
// full_bank marks the two banks that map all of work RAM (0x7E, 0x7F).
// Assumes BANK_W is 8.
module bank_class_dec #(
    parameter int BANK_W = 8
) (
    input  logic [BANK_W-1:0] bank,
    output logic              io_bank,
    output logic              full_bank
);
    // Bank-range compare for both classes.
    always_comb begin
        io_bank   = (bank < 8'h40) || (bank >= 8'h80 && bank < 8'hC0);
        full_bank = (bank == 8'h7E) || (bank == 8'h7F);
    end
endmodule

// File: rtl/mmio_window_dec.sv
// Inclusive range compare for one register window.
// Assumes LO <= HI.
module mmio_window_dec #(
    parameter int                OFS_W = 16,
    parameter logic [OFS_W-1:0]  LO    = '0,
    parameter logic [OFS_W-1:0]  HI    = '0
) (
    input  logic [OFS_W-1:0] offset,
    output logic             hit
);
    // Offset against both bounds.
    always_comb hit = (offset >= LO) && (offset <= HI);
endmodule

// File: rtl/wram_map_dec.sv
// Work-RAM select and address. Either the low mirror in I/O banks, or the
// full space in the two dedicated banks, where bank bit 0 picks the half.
// Assumes io_bank and full_bank are never both high.
module wram_map_dec #(
    parameter int OFS_W   = 16,
    parameter int WRAM_AW = 17,
    parameter int LOW_AW  = 13
) (
    input  logic               io_bank,
    input  logic               full_bank,
    input  logic               bank_lsb,
    input  logic [OFS_W-1:0]   offset,
    output logic               sel,
    output logic [WRAM_AW-1:0] addr
);
    localparam int HI_W = OFS_W - LOW_AW;

    logic low_hit;

    // Low mirror window: upper offset bits all zero.
    always_comb low_hit = io_bank && (offset[OFS_W-1:LOW_AW] == '0);

    // Select and address formation.
    always_comb begin
        sel  = low_hit || full_bank;
        addr = '0;
        if (full_bank)
            addr = {bank_lsb, offset};
        else if (low_hit)
            addr = {{(WRAM_AW-LOW_AW){1'b0}}, offset[LOW_AW-1:0]};
    end

    // Checks on the formed address.
    always_comb begin
        // R6
        mirror_range_chk: assert (!(sel && !full_bank) || addr[WRAM_AW-1:LOW_AW] == '0)
            else $error("mirror address out of 8 KiB");
        // R7
        full_offset_chk: assert (!(sel && full_bank) || addr[OFS_W-1:0] == offset)
            else $error("full-bank address lost offset");
        // R9
        idle_addr_chk: assert (sel || addr == '0)
            else $error("address not zero while deselected");
    end
endmodule

// File: rtl/sys_addr_decoder.sv
// Top: fixed banked address decode into register-window select, work-RAM
// select with address, and an unmapped flag. Purely combinational.
// Assumes the map in sysbus_map_pkg.
module sys_addr_decoder
    import sysbus_map_pkg::*;
#(
    parameter int P_BANK_W  = BANK_W,
    parameter int P_OFS_W   = OFS_W,
    parameter int P_WRAM_AW = WRAM_AW
) (
    input  logic [P_BANK_W-1:0]  bank,
    input  logic [P_OFS_W-1:0]   offset,
    output logic                 mmio_sel,
    output logic                 wram_sel,
    output logic [P_WRAM_AW-1:0] wram_addr,
    output logic                 unmapped
);
    logic               io_bank;
    logic               full_bank;
    logic [NUM_WIN-1:0] win_hit;

    bank_class_dec #(.BANK_W(P_BANK_W)) u_bank (
        .bank      (bank),
        .io_bank   (io_bank),
        .full_bank (full_bank)
    );

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        localparam win_t W = win_of(g);
        mmio_window_dec #(.OFS_W(P_OFS_W), .LO(W.lo), .HI(W.hi)) u_win (
            .offset (offset),
            .hit    (win_hit[g])
        );
    end

    wram_map_dec #(.OFS_W(P_OFS_W), .WRAM_AW(P_WRAM_AW), .LOW_AW(LOW_AW)) u_wram (
        .io_bank   (io_bank),
        .full_bank (full_bank),
        .bank_lsb  (bank[0]),
        .offset    (offset),
        .sel       (wram_sel),
        .addr      (wram_addr)
    );

    // Register-window select gated by I/O bank class.
    always_comb mmio_sel = io_bank && (|win_hit);

    // Fallback flag when no region claims the address.
    always_comb unmapped = !(mmio_sel || wram_sel);

    // Cross-region checks.
    always_comb begin
        // R8
        one_region_chk: assert ($onehot({mmio_sel, wram_sel, unmapped}))
            else $error("region selects not exclusive");
        // R5
        mmio_bank_chk: assert (!mmio_sel || !bank[6])
            else $error("register select outside I/O banks");
    end
endmodule

// File: tb/sim_sys_addr_decoder.sv
`timescale 1ns/1ps
module sim_sys_addr_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bank = '0;
    logic [15:0] offset = '0;
    logic        mmio_sel, wram_sel, unmapped;
    logic [16:0] wram_addr;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        bit          mm;
        bit          wr;
        bit          un;
        logic [16:0] a;
        logic [7:0]  b;
        logic [15:0] o;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    sys_addr_decoder u0 (
        .bank(bank), .offset(offset), .mmio_sel(mmio_sel),
        .wram_sel(wram_sel), .wram_addr(wram_addr), .unmapped(unmapped)
    );

    function automatic exp_t model(input logic [7:0] b, input logic [15:0] o);
        exp_t e;
        bit io, full;
        int w;
        io   = (b < 8'h40) || (b >= 8'h80 && b < 8'hC0);
        full = (b == 8'h7E) || (b == 8'h7F);
        w = 0;
        if (o >= 16'h2140 && o <= 16'h2183) w = 1;
        if (o >= 16'h4016 && o <= 16'h4017) w = 2;
        if (o >= 16'h4200 && o <= 16'h421F) w = 3;
        if (o >= 16'h4300 && o <= 16'h437F) w = 4;
        e.b = b; e.o = o;
        e.mm = io && (w != 0);
        e.wr = (io && o < 16'h2000) || full;
        e.a  = full ? {b[0], o} : ((io && o < 16'h2000) ? {4'b0, o[12:0]} : 17'h0);
        e.un = !(e.mm || e.wr);
        if (w != 0 && io) e.tag = $sformatf("R%0d", w);
        else if (w != 0)  e.tag = "R5";
        else if (full)    e.tag = "R7";
        else if (e.wr)    e.tag = "R6";
        else              e.tag = "R8 R9";
        return e;
    endfunction

    // Driver: apply an address and queue its expectation.
    task automatic drive(input logic [7:0] b, input logic [15:0] o);
        @(posedge clk);
        bank   <= b;
        offset <= o;
        sb.push_back(model(b, o));
    endtask

    // Monitor: compare outputs mid-cycle against the oldest expectation.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (mmio_sel !== e.mm || wram_sel !== e.wr ||
                    unmapped !== e.un || wram_addr !== e.a) begin
                    failures++;
                    $display("FAIL %s addr=%02h:%04h got mm=%0b wr=%0b un=%0b a=%05h exp mm=%0b wr=%0b un=%0b a=%05h",
                             e.tag, e.b, e.o, mmio_sel, wram_sel, unmapped, wram_addr,
                             e.mm, e.wr, e.un, e.a);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #500000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    localparam logic [7:0] BANKS [10] = '{8'h00, 8'h3F, 8'h40, 8'h7D, 8'h7E,
                                          8'h7F, 8'h80, 8'hBF, 8'hC0, 8'hFF};
    localparam logic [15:0] OFS [21] = '{16'h0000, 16'h1FFF, 16'h2000, 16'h213F,
        16'h2140, 16'h2183, 16'h2184, 16'h4015, 16'h4016, 16'h4017, 16'h4018,
        16'h41FF, 16'h4200, 16'h421F, 16'h4220, 16'h42FF, 16'h4300, 16'h437F,
        16'h4380, 16'h8000, 16'hFFFF};

    // Stimulus: reset-state address first, then edges of every window and bank.
    initial begin
        repeat (3) @(posedge clk);
        rst_n <= 1'b1;
        drive(8'h00, 16'h0000);          // reset-state address, R6
        for (int i = 0; i < 10; i++)
            for (int j = 0; j < 21; j++)
                drive(BANKS[i], OFS[j]); // R1 R2 R3 R4 R5 R6 R7 R8 R9
        drive(8'h7E, 16'h1234);          // R7 lower half
        drive(8'h7F, 16'h1234);          // R7 upper half
        drive(8'h9A, 16'h0ABC);          // R6 mirror in upper I/O range
        repeat (3) @(posedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule